// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Grouped Sub-Sources

This block collects up to 32 main interrupt requests and 11 secondary requests and turns them into a single interrupt line for the processor. Secondary requests are latched in their own pending register and filtered by their own mask. They are then folded in groups onto shared main lines, so several small events (for example three per serial port) appear to the main controller as one source. Each main line has a pending latch that sets on a rising request edge and a main mask. A fixed-priority arbiter moves the winning source into a one-hot active register, and software reads the index of that bit.

Software uses a plain 32-bit word bus with combinational reads. An interrupt service routine reads the index and clears the matching secondary pending bit if the source is a grouped one. It then clears the main pending bit and finally the active bit. Once the active register is empty, the arbiter hands over the next eligible source.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Word address 0 is the main pending register. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R2: A main pending bit sets only on a rising edge of that line's request. A request held high does not set the bit again after software clears it.
- R3: When a rising edge and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R4: Word address 1 is the main mask, where 1 means masked, and it resets to all ones. A masked pending source never enters the active register.
- R5: Among the eligible sources (pending and not masked), the lowest-numbered one wins.
- R6: The active register (word address 2) never has more than one bit set. It loads a new winner only while it is empty, so a later, higher-priority source does not replace a bit already held.
- R7: Word address 3 reads the bit index of the active bit, or 0 when the active register is empty. The irq output is high exactly while the active register is non-zero.
- R8: Word address 5 is the secondary mask, where 1 means masked, and it resets to 0x7FF. Word address 4 is the secondary pending register: a rising secondary request sets a bit, and writing 1 to a bit clears it.
- R9: Secondary sources 0–2 drive main line 28, 3–5 drive line 23, 6–8 drive line 15, and 9–10 drive line 31. A secondary source drives its line only while it is pending and unmasked.
- R10: Writing 1 to an active bit clears it. Writing all ones empties the register and drops irq, and writing 0 leaves it unchanged.
- R11: Reads from word addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| main_req_i | input | 32 | Main interrupt request lines |
| sub_req_i | input | 11 | Secondary request lines |
| bus_addr_i | input | 3 | Word address of register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt to processor |

## Verification
Two pairs of events can land on the same edge. The first is a rising request and a software clear of the same pending bit. The bench lines up the request edge with the write strobe in one drive step and expects the bit to read back set. The second is a latched active bit competing with a newly arriving higher-priority source. The bench raises the lower-priority line first, then the higher one. It expects the index to hold until software clears the active bit, and then to move to the remaining source.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      REG_SRC_PEND  = 3'd0,
      REG_MAIN_MASK = 3'd1,
      REG_ACT_PEND  = 3'd2,
      REG_ACT_INDEX = 3'd3,
      REG_SUB_PEND  = 3'd4,
      REG_SUB_MASK  = 3'd5
   } cic_reg_e;
endpackage

// File: rtl/cic_edge_pend.sv
module cic_edge_pend #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] req_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);
   logic [W-1:0] req_q;
   logic [W-1:0] pend_q;
   logic [W-1:0] rise;

   assign rise = req_i & ~req_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q  <= '0;
         pend_q <= '0;
      end else begin
         req_q  <= req_i;
         pend_q <= (pend_q & ~clr_i) | rise;
      end
   end

   assign pend_o = pend_q;

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise))); // R3

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise == '0) |=> ((pend_q & ~$past(pend_q)) == '0)); // R2
endmodule

// File: rtl/cic_sub_fold.sv
module cic_sub_fold #(
   parameter int NUM_MAIN    = 32,
   parameter int NUM_SUB     = 11,
   parameter int SUB_PER_GRP = 3,
   parameter int NUM_GRP     = 4,
   parameter int LINE_W      = 5,
   parameter logic [NUM_GRP*LINE_W-1:0] GRP_LINE = '0
) (
   input  logic [NUM_MAIN-1:0] main_req_i,
   input  logic [NUM_SUB-1:0]  sub_pend_i,
   input  logic [NUM_SUB-1:0]  sub_mask_i,
   output logic [NUM_MAIN-1:0] line_req_o
);
   logic [NUM_SUB-1:0] sub_live;
   logic [NUM_GRP-1:0] grp_hit;

   assign sub_live = sub_pend_i & ~sub_mask_i;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [SUB_PER_GRP-1:0] members;
      for (genvar k = 0; k < SUB_PER_GRP; k++) begin : g_member
         if (g * SUB_PER_GRP + k < NUM_SUB) begin : g_real
            assign members[k] = sub_live[g*SUB_PER_GRP+k];
         end else begin : g_pad
            assign members[k] = 1'b0;
         end
      end
      assign grp_hit[g] = |members;
   end

   always_comb begin
      line_req_o = main_req_i;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (grp_hit[g]) line_req_o[GRP_LINE[g*LINE_W +: LINE_W]] = 1'b1;
      end
   end
endmodule

// File: rtl/cic_arbiter.sv
module cic_arbiter #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [N-1:0]  src_i,
   input  logic [N-1:0]  mask_i,
   input  logic [N-1:0]  clr_i,
   output logic [N-1:0]  act_o,
   output logic [IW-1:0] index_o,
   output logic          irq_o
);
   logic [N-1:0] eligible;
   logic [N-1:0] winner;
   logic [N-1:0] act_q;

   assign eligible = src_i & ~mask_i;

   always_comb begin
      winner = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (eligible[i]) begin
            winner    = '0;
            winner[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          act_q <= '0;
      else if (act_q == '0) act_q <= winner;
      else                  act_q <= act_q & ~clr_i;
   end

   always_comb begin
      index_o = '0;
      for (int i = 0; i < N; i++) begin
         if (act_q[i]) index_o = IW'(i);
      end
   end

   assign act_o = act_q;
   assign irq_o = |act_q;

   AST_ACT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(act_q)); // R6

   AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((act_q != '0) && ((act_q & clr_i) == '0)) |=> (act_q == $past(act_q))); // R6

   AST_MASKED_NEVER_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q == '0) |=> ((act_q & $past(mask_i)) == '0)); // R4

   AST_IRQ_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> act_q[index_o]); // R7
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
   parameter int NUM_MAIN    = 32,
   parameter int NUM_SUB     = 11,
   parameter int SUB_PER_GRP = 3,
   parameter int NUM_GRP     = 4,
   parameter int LINE_W      = 5,
   parameter int DW          = 32,
   parameter logic [NUM_GRP*LINE_W-1:0] GRP_LINE = {5'd31, 5'd15, 5'd23, 5'd28}
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [NUM_MAIN-1:0]       main_req_i,
   input  logic [NUM_SUB-1:0]        sub_req_i,
   input  logic [cic_pkg::REG_AW-1:0] bus_addr_i,
   input  logic                      bus_wr_i,
   input  logic [DW-1:0]             bus_wdata_i,
   output logic [DW-1:0]             bus_rdata_o,
   output logic                      irq_o
);
   import cic_pkg::*;

   localparam int IW = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1;

   if (NUM_MAIN > DW) begin : g_chk_main
      $error("NUM_MAIN exceeds bus width");
   end
   if (NUM_SUB > DW) begin : g_chk_sub_w
      $error("NUM_SUB exceeds bus width");
   end
   if (NUM_SUB > NUM_GRP * SUB_PER_GRP) begin : g_chk_grp
      $error("groups cannot hold all secondary sources");
   end
   if (LINE_W < IW) begin : g_chk_line
      $error("LINE_W too narrow for main line index");
   end

   logic [NUM_MAIN-1:0] main_mask_q;
   logic [NUM_SUB-1:0]  sub_mask_q;
   logic [NUM_MAIN-1:0] src_clr, act_clr, line_req, src_pend, act_pend;
   logic [NUM_SUB-1:0]  sub_clr, sub_pend;
   logic [IW-1:0]       act_index;

   function automatic logic hit(input logic wr, input logic [REG_AW-1:0] a,
                                input cic_reg_e r);
      return wr && (a == r);
   endfunction

   assign src_clr = hit(bus_wr_i, bus_addr_i, REG_SRC_PEND) ? bus_wdata_i[NUM_MAIN-1:0] : '0;
   assign act_clr = hit(bus_wr_i, bus_addr_i, REG_ACT_PEND) ? bus_wdata_i[NUM_MAIN-1:0] : '0;
   assign sub_clr = hit(bus_wr_i, bus_addr_i, REG_SUB_PEND) ? bus_wdata_i[NUM_SUB-1:0]  : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         main_mask_q <= '1;
         sub_mask_q  <= '1;
      end else begin
         if (hit(bus_wr_i, bus_addr_i, REG_MAIN_MASK)) main_mask_q <= bus_wdata_i[NUM_MAIN-1:0];
         if (hit(bus_wr_i, bus_addr_i, REG_SUB_MASK))  sub_mask_q  <= bus_wdata_i[NUM_SUB-1:0];
      end
   end

   cic_edge_pend #(.W(NUM_SUB)) u_sub_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (sub_req_i),
      .clr_i  (sub_clr),
      .pend_o (sub_pend)
   );

   cic_sub_fold #(
      .NUM_MAIN    (NUM_MAIN),
      .NUM_SUB     (NUM_SUB),
      .SUB_PER_GRP (SUB_PER_GRP),
      .NUM_GRP     (NUM_GRP),
      .LINE_W      (LINE_W),
      .GRP_LINE    (GRP_LINE)
   ) u_fold (
      .main_req_i (main_req_i),
      .sub_pend_i (sub_pend),
      .sub_mask_i (sub_mask_q),
      .line_req_o (line_req)
   );

   cic_edge_pend #(.W(NUM_MAIN)) u_src_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (line_req),
      .clr_i  (src_clr),
      .pend_o (src_pend)
   );

   cic_arbiter #(.N(NUM_MAIN), .IW(IW)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_pend),
      .mask_i  (main_mask_q),
      .clr_i   (act_clr),
      .act_o   (act_pend),
      .index_o (act_index),
      .irq_o   (irq_o)
   );

   always_comb begin
      case (bus_addr_i)
         REG_SRC_PEND:  bus_rdata_o = DW'(src_pend);
         REG_MAIN_MASK: bus_rdata_o = DW'(main_mask_q);
         REG_ACT_PEND:  bus_rdata_o = DW'(act_pend);
         REG_ACT_INDEX: bus_rdata_o = DW'(act_index);
         REG_SUB_PEND:  bus_rdata_o = DW'(sub_pend);
         REG_SUB_MASK:  bus_rdata_o = DW'(sub_mask_q);
         default:       bus_rdata_o = '0;
      endcase
   end

   AST_MASK_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit(bus_wr_i, bus_addr_i, REG_MAIN_MASK) |=> $stable(main_mask_q)); // R4

   AST_SUB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sub_clr & ~sub_req_i) != '0) |=> ((sub_pend & $past(sub_clr & ~sub_req_i)) == '0)); // R8
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] main_req = '0;
   logic [10:0] sub_req = '0;
   logic [2:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cascade_irq_ctrl u_dut (
      .clk_i (clk), .rst_ni (rst_n), .main_req_i (main_req), .sub_req_i (sub_req),
      .bus_addr_i (addr), .bus_wr_i (wr), .bus_wdata_i (wdata),
      .bus_rdata_o (rdata), .irq_o (irq)
   );

   typedef struct packed {
      logic [31:0] mask;
      logic [31:0] req;
      logic [31:0] exp_idx;
      logic        exp_irq;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{32'h0000_0000, 32'h0000_0001, 32'd0,  1'b1},
      '{32'h0000_0000, 32'h8000_0000, 32'd31, 1'b1},
      '{32'h0000_0000, 32'h0000_0F00, 32'd8,  1'b1},
      '{32'h0000_00FF, 32'h0000_0181, 32'd8,  1'b1},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0,  1'b0},
      '{32'hFFFF_FFFE, 32'h0000_0002, 32'd0,  1'b0},
      '{32'h0000_0000, 32'h0101_0000, 32'd16, 1'b1},
      '{32'hFFFF_0000, 32'hFFFF_8000, 32'd15, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clean_all();
      main_req = '0; sub_req = '0;
      wait_cycles(1);
      bus_write(3'd5, 32'h0000_07FF);
      bus_write(3'd4, 32'hFFFF_FFFF);
      bus_write(3'd0, 32'hFFFF_FFFF);
      bus_write(3'd2, 32'hFFFF_FFFF);
   endtask

   task automatic sub_case(input int s, input int line);
      logic [31:0] d;
      clean_all();
      bus_write(3'd1, 32'h0);
      bus_write(3'd5, 32'h7FF & ~(32'd1 << s));
      @(negedge clk);
      sub_req[s] = 1'b1;
      wait_cycles(3);
      bus_read(3'd3, d);
      chk($sformatf("R9 sub %0d index", s), d, 32'(line));
      chk($sformatf("R9 sub %0d irq", s), {31'd0, irq}, 32'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      wait_cycles(3);
      rst_n = 1'b1;

      // reset state
      bus_read(3'd5, d); chk("R8 sub mask reset", d, 32'h0000_07FF);
      bus_read(3'd1, d); chk("R4 main mask reset", d, 32'hFFFF_FFFF);
      bus_read(3'd3, d); chk("R7 index empty", d, 32'd0);
      chk("R7 irq reset", {31'd0, irq}, 32'd0);
      bus_read(3'd0, d); chk("R1 pending reset", d, 32'd0);
      bus_read(3'd6, d); chk("R11 unused addr 6", d, 32'd0);
      bus_read(3'd7, d); chk("R11 unused addr 7", d, 32'd0);

      // vector table: priority and masking
      foreach (VECS[v]) begin
         main_req = '0;
         wait_cycles(1);
         bus_write(3'd1, VECS[v].mask);
         bus_write(3'd0, 32'hFFFF_FFFF);
         bus_write(3'd2, 32'hFFFF_FFFF);
         main_req = VECS[v].req;
         wait_cycles(3);
         bus_read(3'd3, d);
         chk($sformatf("R5 vec %0d index", v), d, VECS[v].exp_idx);
         chk($sformatf("R4 vec %0d irq", v), {31'd0, irq}, {31'd0, VECS[v].exp_irq});
      end

      // R1: write-one-to-clear on main pending
      clean_all();
      bus_write(3'd1, 32'hFFFF_FFFF);
      main_req = 32'h0000_00F0;
      wait_cycles(2);
      bus_read(3'd0, d); chk("R2 edge sets pending", d, 32'h0000_00F0);
      bus_write(3'd0, 32'h0000_0030);
      bus_read(3'd0, d); chk("R1 clear ones", d, 32'h0000_00C0);
      bus_write(3'd0, 32'h0);
      bus_read(3'd0, d); chk("R1 zero write no effect", d, 32'h0000_00C0);
      // R2: held level does not re-set
      bus_write(3'd0, 32'hFFFF_FFFF);
      wait_cycles(2);
      bus_read(3'd0, d); chk("R2 held level stays cleared", d, 32'h0);
      main_req = '0;
      wait_cycles(1);
      main_req = 32'h0000_0010;
      wait_cycles(2);
      bus_read(3'd0, d); chk("R2 new edge sets again", d, 32'h0000_0010);

      // R3: rising edge and clear in the same cycle
      clean_all();
      @(negedge clk);
      wr = 1'b1; addr = 3'd0; wdata = 32'h0000_0008; main_req = 32'h0000_0008;
      @(negedge clk);
      wr = 1'b0;
      bus_read(3'd0, d); chk("R3 set beats clear", d, 32'h0000_0008);

      // R6 / R10: hold while occupied, then hand over
      clean_all();
      bus_write(3'd1, ~32'h0000_0024);
      main_req = 32'h0000_0020;
      wait_cycles(3);
      bus_read(3'd3, d); chk("R6 first winner", d, 32'd5);
      main_req = 32'h0000_0024;
      wait_cycles(3);
      bus_read(3'd3, d); chk("R6 held despite higher priority", d, 32'd5);
      bus_read(3'd2, d); chk("R6 single active bit", d, 32'h0000_0020);
      bus_write(3'd2, 32'h0);
      bus_read(3'd2, d); chk("R10 zero write keeps active", d, 32'h0000_0020);
      bus_write(3'd0, 32'h0000_0020);
      bus_write(3'd2, 32'h0000_0020);
      wait_cycles(1);
      bus_read(3'd3, d); chk("R6 handover index", d, 32'd2);
      bus_write(3'd0, 32'hFFFF_FFFF);
      bus_write(3'd2, 32'hFFFF_FFFF);
      bus_read(3'd2, d); chk("R10 all ones empties", d, 32'h0);
      chk("R7 irq low when empty", {31'd0, irq}, 32'd0);
      bus_read(3'd3, d); chk("R7 index zero when empty", d, 32'd0);

      // R9: grouped secondary sources
      sub_case(1, 28);
      sub_case(4, 23);
      sub_case(7, 15);
      sub_case(10, 31);
      // masked secondary: pending but does not reach line 28
      sub_case(4, 23);
      @(negedge clk);
      sub_req[0] = 1'b1;
      wait_cycles(3);
      bus_read(3'd4, d); chk("R8 masked sub still pends", d, 32'h0000_0011);
      bus_read(3'd0, d); chk("R9 masked sub no main", d & 32'h1000_0000, 32'h0);
      sub_req = '0;
      wait_cycles(1);
      bus_write(3'd4, 32'h0000_0010);
      bus_read(3'd4, d); chk("R8 sub clear", d, 32'h0000_0001);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule